// File: doc/BRIEF.md
# Chainable Four-Channel Converter Serial Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host writes 12-bit command frames over a three-wire serial port made of a serial clock, a data line and an active-low select. The block keeps two registers per channel. The staging register receives new codes. The output register drives the converter code. A frame is decoded only when the select line returns high, so every device that shares the select line updates in the same cycle.

Every bit that enters the frame shift register is passed on through a serial data output, exactly one frame length later. Wiring that output to the data input of the next device builds a chain of any length on shared clock and select wires. The no-operation command lets a frame pass through a device without touching any of its registers.

The serial pins are asynchronous to the block clock. They are resynchronised and edge-detected inside the block. Both timing modes work: clock idling low with the rising edge as the sample edge, and clock idling high with the rising edge still sampling, provided the data output is not used.

Top module: `quad_dac_link`

## Requirements
- R1: After reset all four output codes read zero, every staging register is zero (a copy-all command issued straight after reset leaves the outputs at zero), and the serial data output is low.
- R2: While select is low, the data line is sampled on each rising serial clock edge into a 12-bit register, most significant bit first. When a frame is decoded, bits [11:10] are the channel (0 = channel 0 … 3 = channel 3), bits [9:8] are the command, and bits [7:0] are the code. Output code of channel n appears on dacCodes[8n+7:8n].
- R3: Command 01 writes the code into the addressed staging register only; no output code changes.
- R4: Command 10 writes the code into the addressed staging register and copies all four staging registers, including the new code, to the outputs in the same commit.
- R5: Command 11 copies all four staging registers to the outputs and ignores the code field.
- R6: Command 00 changes no staging register and no output code.
- R7: Output codes change only on the rising edge of select; they hold while a frame is being shifted in.
- R8: After each falling serial clock edge with select low, the serial data output presents the current most significant bit of the shift register, so the bit seen before rising edge k is the data bit sampled at rising edge k-12. Feeding it to a second device delivers the earlier frame of a 24-bit stream to that device.
- R9: If select rises after a bit count other than 12, the last 12 bits shifted in are decoded.
- R10: While select is high, serial clock edges neither shift the register nor change the serial data output. Pulsing select low and high again with no clock edges decodes the held frame again.
- R11: Frames sent with the serial clock idling high (rising edge sampling) decode the same as frames sent with it idling low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| din | input | 1 | Serial data in |
| csN | input | 1 | Active-low frame select |
| dout | output | 1 | Serial data out for chaining |
| dacCodes | output | 32 | Four 8-bit output codes, channel n in bits [8n+7:8n] |

## Verification
The assertions assume that the serial pins change slowly against the block clock. Each serial clock phase must last longer than the synchroniser plus the edge detector, which is at least three block clocks. The data line must be steady across the synchronised rising edge, and select must not move in the same cycle as a serial clock edge. The stimulus keeps every phase at six block clocks. It changes data only with or after the falling edge, and it leaves several idle cycles between the last clock edge and the select transition, so every strobe the assertions reason about comes from a clean edge.

// File: rtl/quad_dac_link_pkg.sv
package quad_dac_link_pkg;
  localparam int CH_COUNT = 4;
  localparam int CODE_W   = 8;
  localparam int ADDR_W   = $clog2(CH_COUNT);
  localparam int CTL_W    = 2;
  localparam int FRAME_W  = ADDR_W + CTL_W + CODE_W;

  typedef enum logic [CTL_W-1:0] {
    CTL_NOP      = 2'b00,
    CTL_LOAD     = 2'b01,
    CTL_LOAD_UPD = 2'b10,
    CTL_UPD      = 2'b11
  } ctl_e;

  typedef struct packed {
    logic shift;
    logic outUpd;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/qdl_ctrl.sv
module qdl_ctrl
  import quad_dac_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    din,
  input  logic    csN,
  output logic    dinSync,
  output strobe_t strb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclkPipe;
  logic [TOP:0] dinPipe;
  logic [TOP:0] csPipe;
  logic         sclkPrev;
  logic         csPrev;
  logic         sclkNow;
  logic         csNow;

  // Synchronisers; select resets to its idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      dinPipe  <= '0;
      csPipe   <= '1;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[TOP-1:0], sclk};
      dinPipe  <= {dinPipe[TOP-1:0], din};
      csPipe   <= {csPipe[TOP-1:0], csN};
      sclkPrev <= sclkPipe[TOP];
      csPrev   <= csPipe[TOP];
    end
  end

  assign sclkNow = sclkPipe[TOP];
  assign csNow   = csPipe[TOP];
  assign dinSync = dinPipe[TOP];

  always_comb begin
    strb.shift  = !csNow && sclkNow && !sclkPrev;
    strb.outUpd = !csNow && !sclkNow && sclkPrev;
    strb.commit = csNow && !csPrev;
  end

  // R7: a commit never coincides with shifting or output update
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R10: with select held high no strobe of the serial side fires
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (csNow && csPrev) |-> (!strb.shift && !strb.outUpd));
endmodule

// File: rtl/qdl_datapath.sv
module qdl_datapath
  import quad_dac_link_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dinSync,
  input  strobe_t                    strb,
  output logic                       dout,
  output logic [CH_COUNT*CODE_W-1:0] dacFlat
);
  logic [FRAME_W-1:0]         shiftReg;
  logic [ADDR_W-1:0]          addrField;
  ctl_e                       ctlField;
  logic [CODE_W-1:0]          dataField;
  logic                       doLoad;
  logic                       doUpd;
  logic [CODE_W-1:0]          inReg  [CH_COUNT];
  logic [CODE_W-1:0]          dacReg [CH_COUNT];
  logic [CH_COUNT*CODE_W-1:0] inFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], dinSync};
  end

  // Data out follows the register head after each falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dout <= 1'b0;
    else if (strb.outUpd) dout <= shiftReg[FRAME_W-1];
  end

  assign addrField = shiftReg[FRAME_W-1 -: ADDR_W];
  assign ctlField  = ctl_e'(shiftReg[CODE_W +: CTL_W]);
  assign dataField = shiftReg[CODE_W-1:0];
  assign doLoad    = strb.commit && (ctlField == CTL_LOAD || ctlField == CTL_LOAD_UPD);
  assign doUpd     = strb.commit && (ctlField == CTL_LOAD_UPD || ctlField == CTL_UPD);

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    logic              hit;
    logic [CODE_W-1:0] nextIn;

    assign hit    = doLoad && (addrField == ADDR_W'(ch));
    assign nextIn = hit ? dataField : inReg[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg[ch]  <= '0;
        dacReg[ch] <= '0;
      end else begin
        inReg[ch] <= nextIn;
        if (doUpd) dacReg[ch] <= nextIn;
      end
    end

    assign inFlat[ch*CODE_W +: CODE_W]  = inReg[ch];
    assign dacFlat[ch*CODE_W +: CODE_W] = dacReg[ch];
  end

  // R10: register moves only on a shift strobe
  a_r10_shift_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(shiftReg));

  // R8: data out moves only after a falling edge
  a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outUpd |=> $stable(dout));

  // R7: outputs move only on commit
  a_r7_dac_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacFlat));

  // R6: no-operation touches nothing
  a_r6_nop_still: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ctlField == CTL_NOP) |=> ($stable(inFlat) && $stable(dacFlat)));

  // R3: staging-only write leaves outputs alone
  a_r3_load_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ctlField == CTL_LOAD) |=> $stable(dacFlat));

  // R4: write-and-copy leaves outputs equal to staging
  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ctlField == CTL_LOAD_UPD) |=> (dacFlat == inFlat));

  // R5: copy-all takes the previous staging contents unchanged
  a_r5_copy_all: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && ctlField == CTL_UPD) |=> (dacFlat == $past(inFlat) && $stable(inFlat)));
endmodule

// File: rtl/quad_dac_link.sv
module quad_dac_link
  import quad_dac_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       din,
  input  logic                       csN,
  output logic                       dout,
  output logic [CH_COUNT*CODE_W-1:0] dacCodes
);
  logic    dinSync;
  strobe_t strb;

  qdl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .din     (din),
    .csN     (csN),
    .dinSync (dinSync),
    .strb    (strb)
  );

  qdl_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dinSync (dinSync),
    .strb    (strb),
    .dout    (dout),
    .dacFlat (dacCodes)
  );

  initial begin
    a_r2_sync_depth: assert (SYNC_STAGES >= 2);
  end
endmodule

// File: tb/tb_quad_dac_link.sv
module tb_quad_dac_link;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        csN = 1'b1;
  logic        dout;
  logic        dout2;
  logic [31:0] dac;
  logic [31:0] dac2;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  quad_dac_link dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .din(din), .csN(csN),
    .dout(dout), .dacCodes(dac)
  );

  quad_dac_link dut2 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .din(dout), .csN(csN),
    .dout(dout2), .dacCodes(dac2)
  );

  // frame (12 bits) then expected output codes {ch3,ch2,ch1,ch0}
  localparam logic [43:0] VEC [8] = '{
    {12'h111, 32'h00000000},   // R3 load ch0
    {12'h522, 32'h00000000},   // R3 load ch1
    {12'hA33, 32'h00332211},   // R4 load ch2 and copy
    {12'hD44, 32'h00332211},   // R3 load ch3
    {12'hCFF, 32'h00332211},   // R6 no-op
    {12'h3AA, 32'h44332211},   // R5 copy, code ignored
    {12'h280, 32'h44332280},   // R4 overwrite ch0 and copy
    {12'h5FF, 32'h44332280}    // R3 load ch1 only
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic openFrame(input bit mode3);
    sclk = mode3;
    idle(H);
    csN = 1'b0;
    idle(H);
  endtask

  task automatic closeFrame();
    idle(H);
    csN = 1'b1;
    idle(8);
    sclk = 1'b0;
    idle(8);
  endtask

  task automatic shiftBits(input logic [31:0] bits, input int n, input bit mode3,
                           input bit chkDout);
    for (int i = 0; i < n; i++) begin
      if (mode3) sclk = 1'b0;
      din = bits[n-1-i];
      idle(H);
      if (chkDout && i >= 12) chk("R8 dout lag", {31'd0, dout}, {31'd0, bits[n-1-(i-12)]});
      sclk = 1'b1;
      idle(H);
      if (!mode3) sclk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [11:0] f, input bit mode3);
    openFrame(mode3);
    shiftBits({20'd0, f}, 12, mode3, 1'b0);
    closeFrame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    chk("R1 reset dac", dac, 32'h0);
    chk("R1 reset dout", {31'd0, dout}, 32'h0);
    rstN = 1'b1;
    idle(5);

    // table walk, with mid-frame hold check
    for (int v = 0; v < 8; v++) begin
      logic [31:0] prev;
      prev = dac;
      openFrame(1'b0);
      shiftBits({20'd0, VEC[v][43:32]}, 12, 1'b0, 1'b0);
      chk("R7 hold before select rise", dac, prev);
      closeFrame();
      chk("R2-table R3 R4 R5 R6 frame result", dac, VEC[v][31:0]);
    end

    // R9: 15 bits, last 12 are copy-all
    openFrame(1'b0);
    shiftBits(32'h5300, 15, 1'b0, 1'b0);
    closeFrame();
    chk("R9 last 12 bits decoded", dac, 32'h4433FF80);

    // R10: clock with select high is ignored
    sendFrame(12'h101, 1'b0);
    chk("R3 load ch0 staging", dac, 32'h4433FF80);
    begin
      logic heldOut;
      heldOut = dout;
      din = 1'b1;
      for (int i = 0; i < 12; i++) begin
        sclk = 1'b1; idle(H);
        sclk = 1'b0; idle(H);
      end
      chk("R10 dout held", {31'd0, dout}, {31'd0, heldOut});
    end
    din = 1'b0;
    openFrame(1'b0);
    closeFrame();
    chk("R10 held frame re-decoded", dac, 32'h4433FF80);
    sendFrame(12'h300, 1'b0);
    chk("R5 copy shows staged ch0", dac, 32'h4433FF01);

    // R11: clock idling high
    sendFrame(12'h2C5, 1'b1);
    chk("R11 idle-high frame", dac, 32'h4433FFC5);

    // R8: chain of two, first frame reaches dut2
    openFrame(1'b0);
    shiftBits({8'd0, 12'h65A, 12'h000}, 24, 1'b0, 1'b1);
    closeFrame();
    chk("R8 R6 near device no-op", dac, 32'h4433FFC5);
    chk("R8 far device ch1", {24'd0, dac2[15:8]}, 32'h5A);

    // R1: mid-run reset clears staging too
    rstN = 1'b0;
    idle(4);
    chk("R1 reset dac again", dac, 32'h0);
    chk("R1 reset dout again", {31'd0, dout}, 32'h0);
    rstN = 1'b1;
    idle(4);
    sendFrame(12'h300, 1'b0);
    chk("R1 staging cleared", dac, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule